// File: doc/BRIEF.md
# Dual-Speed Single-Wire Bus Master

This block drives one open-drain, single-wire serial line shared with one or more slave devices. A host issues one primitive at a time: a bus reset with presence detection, a one-bit write, or a one-bit read. The block produces the low pulse for that primitive, samples the line at the right moment, and keeps the line released for the rest of the time slot. It then raises a one-cycle completion strobe and presents the result bit.

Two timing sets are available. The normal set is slow and tolerant. The fast set shortens every interval by roughly a factor of ten. The host chooses the set with each command. All intervals come from a single parameter giving clock cycles per microsecond. The line can only be pulled low or released. The level read back from the line passes through a multi-flop synchronizer before any decision uses it.

Top module: `sw_bus_master`

## Requirements
- R1: After reset, `busy`, `done`, `rsp_bit` and `bus_pull_low` are all 0.
- R2: A reset command (`cmd_op` = 2'b00) pulls the line low for 480 µs at normal speed or 48 µs at fast speed. It completes with `done` 960 µs or 96 µs after acceptance, so the full release period has elapsed.
- R3: A reset command samples the line 70 µs (normal) or 9 µs (fast) after the line is released. It sets `rsp_bit` to 1 when the line is low at that moment (a device is present) and to 0 otherwise.
- R4: A write command (`cmd_op` = 2'b01) pulls the line low for 60 µs (normal) or 6 µs (fast) when `cmd_wbit` is 0. It pulls the line low for 6 µs (normal) or 1 µs (fast) when `cmd_wbit` is 1.
- R5: A read command (`cmd_op` = 2'b10) pulls the line low for 5 µs (normal) or 1 µs (fast). It samples the line 12 µs (normal) or 1.5 µs (fast) after the slot starts, and returns the level seen (1 = high) on `rsp_bit`.
- R6: Write and read slots last 70 µs (normal) or 10 µs (fast) from acceptance to `done`. `busy` is high for the whole slot, and the line is pulled low only while `busy` is high.
- R7: `cmd_fast` (1 = fast set) is captured when a command is accepted. Changing it while the command runs has no effect on that command's timing.
- R8: A command presented while `busy` is high is ignored. The encoding 2'b11 is never accepted.
- R9: `rsp_bit` clears to 0 when a command is accepted. It then changes only at the sample point of a reset or read. It holds its value from `done` until the next acceptance; a write leaves it at 0.
- R10: `done` is a single-cycle pulse, and `busy` is low in the cycle `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request, taken when `busy` is low |
| cmd_op | input | 2 | 00 reset, 01 write, 10 read, 11 none |
| cmd_wbit | input | 1 | Bit value for a write |
| cmd_fast | input | 1 | 1 selects the fast timing set |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion strobe |
| rsp_bit | output | 1 | Presence flag or read bit |
| bus_pull_low | output | 1 | 1 pulls the line low, 0 releases it |
| bus_in | input | 1 | Raw line level |

## Verification
The assertions assume that `bus_in` is a free-running asynchronous level. They also assume that the host may hold `cmd_valid` at any time, including while a slot is running, and that the line level matters only at the synchronized sample point. The stimulus models a device that pulls the line low over windows well clear of each sample point. These windows are wider than the synchronizer delay, so the result does not depend on latency of a single cycle. Commands injected during a slot, and speed changes made during a slot, fall well inside the slot so that any ignored request can be seen in the slot length and the pulse width.

// File: rtl/sw_bus_pkg.sv
package sw_bus_pkg;

   typedef enum logic [1:0] {
      OP_RESET = 2'b00,
      OP_WRITE = 2'b01,
      OP_READ  = 2'b10,
      OP_NONE  = 2'b11
   } sw_op_e;

   // Interval table in half-microsecond units, normal set
   localparam int unsigned NRM_RST_LOW  = 960;
   localparam int unsigned NRM_PRES     = 140;
   localparam int unsigned NRM_RST_END  = 1920;
   localparam int unsigned NRM_W0_LOW   = 120;
   localparam int unsigned NRM_W1_LOW   = 12;
   localparam int unsigned NRM_RD_LOW   = 10;
   localparam int unsigned NRM_RD_SAMP  = 24;
   localparam int unsigned NRM_SLOT     = 140;

   // Interval table in half-microsecond units, fast set
   localparam int unsigned FST_RST_LOW  = 96;
   localparam int unsigned FST_PRES     = 18;
   localparam int unsigned FST_RST_END  = 192;
   localparam int unsigned FST_W0_LOW   = 12;
   localparam int unsigned FST_W1_LOW   = 2;
   localparam int unsigned FST_RD_LOW   = 2;
   localparam int unsigned FST_RD_SAMP  = 3;
   localparam int unsigned FST_SLOT     = 20;

   localparam int unsigned MAX_HUS      = NRM_RST_END;

   function automatic int unsigned hus_to_cyc(input int unsigned hus,
                                              input int unsigned cyc_per_us);
      return (hus * cyc_per_us + 1) / 2;
   endfunction

endpackage

// File: rtl/sw_bus_sync.sv
module sw_bus_sync #(
   parameter int unsigned STAGES   = 2,
   parameter bit          RST_VAL  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);

   logic [STAGES-1:0] chain_q;

   generate
      genvar i;
      for (i = 0; i < int'(STAGES); i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= RST_VAL;
               else        chain_q[0] <= d_async;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[i] <= RST_VAL;
               else        chain_q[i] <= chain_q[i-1];
            end
         end
      end
   endgenerate

   assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/sw_bus_timing.sv
module sw_bus_timing
   import sw_bus_pkg::*;
#(
   parameter int unsigned CYC_PER_US = 125,
   parameter int unsigned CNT_W      = 17
) (
   input  logic              sel_fast,
   input  sw_op_e            op,
   input  logic              wbit,
   output logic [CNT_W-1:0]  low_len,
   output logic [CNT_W-1:0]  samp_at,
   output logic [CNT_W-1:0]  end_at,
   output logic              has_samp
);

   logic [CNT_W-1:0] t_rst_low [2];
   logic [CNT_W-1:0] t_rst_smp [2];
   logic [CNT_W-1:0] t_rst_end [2];
   logic [CNT_W-1:0] t_w0_low  [2];
   logic [CNT_W-1:0] t_w1_low  [2];
   logic [CNT_W-1:0] t_rd_low  [2];
   logic [CNT_W-1:0] t_rd_smp  [2];
   logic [CNT_W-1:0] t_slot    [2];

   generate
      genvar s;
      for (s = 0; s < 2; s++) begin : g_speed
         localparam int unsigned RL = hus_to_cyc((s == 0) ? NRM_RST_LOW : FST_RST_LOW, CYC_PER_US);
         localparam int unsigned PS = hus_to_cyc((s == 0) ? NRM_PRES    : FST_PRES,    CYC_PER_US);
         localparam int unsigned RE = hus_to_cyc((s == 0) ? NRM_RST_END : FST_RST_END, CYC_PER_US);
         localparam int unsigned W0 = hus_to_cyc((s == 0) ? NRM_W0_LOW  : FST_W0_LOW,  CYC_PER_US);
         localparam int unsigned W1 = hus_to_cyc((s == 0) ? NRM_W1_LOW  : FST_W1_LOW,  CYC_PER_US);
         localparam int unsigned DL = hus_to_cyc((s == 0) ? NRM_RD_LOW  : FST_RD_LOW,  CYC_PER_US);
         localparam int unsigned DS = hus_to_cyc((s == 0) ? NRM_RD_SAMP : FST_RD_SAMP, CYC_PER_US);
         localparam int unsigned SL = hus_to_cyc((s == 0) ? NRM_SLOT    : FST_SLOT,    CYC_PER_US);

         if (!(W1 < W0 && DL < DS && DS < SL && W0 < SL && RL + PS < RE)) begin : g_bad_order
            $error("sw_bus_timing: interval ordering violated for speed %0d", s);
         end
         if (RE >= (1 << CNT_W)) begin : g_bad_width
            $error("sw_bus_timing: counter width too small");
         end

         assign t_rst_low[s] = CNT_W'(RL);
         assign t_rst_smp[s] = CNT_W'(RL + PS);
         assign t_rst_end[s] = CNT_W'(RE);
         assign t_w0_low[s]  = CNT_W'(W0);
         assign t_w1_low[s]  = CNT_W'(W1);
         assign t_rd_low[s]  = CNT_W'(DL);
         assign t_rd_smp[s]  = CNT_W'(DS);
         assign t_slot[s]    = CNT_W'(SL);
      end
   endgenerate

   logic idx;
   assign idx = sel_fast;

   always_comb begin
      low_len  = '0;
      samp_at  = '0;
      end_at   = t_slot[idx];
      has_samp = 1'b0;
      unique case (op)
         OP_RESET: begin
            low_len  = t_rst_low[idx];
            samp_at  = t_rst_smp[idx];
            end_at   = t_rst_end[idx];
            has_samp = 1'b1;
         end
         OP_WRITE: begin
            low_len  = wbit ? t_w1_low[idx] : t_w0_low[idx];
         end
         OP_READ: begin
            low_len  = t_rd_low[idx];
            samp_at  = t_rd_smp[idx];
            has_samp = 1'b1;
         end
         default: begin
            low_len  = '0;
         end
      endcase
   end

endmodule

// File: rtl/sw_bus_seq.sv
module sw_bus_seq
   import sw_bus_pkg::*;
#(
   parameter int unsigned CNT_W = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  sw_op_e            cmd_op,
   input  logic              cmd_fast,
   input  logic [CNT_W-1:0]  low_len,
   input  logic [CNT_W-1:0]  samp_at,
   input  logic [CNT_W-1:0]  end_at,
   input  logic              has_samp,
   input  logic              line_s,
   output logic              busy,
   output logic              done,
   output logic              rsp_bit,
   output logic              pull_low
);

   logic             busy_q, done_q, rsp_q;
   logic             samp_en_q, is_rst_q, fast_q;
   logic [CNT_W-1:0] cnt_q, low_q, samp_q, last_q;
   logic             accept;

   assign accept = cmd_valid && !busy_q && (cmd_op != OP_NONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         done_q    <= 1'b0;
         rsp_q     <= 1'b0;
         samp_en_q <= 1'b0;
         is_rst_q  <= 1'b0;
         fast_q    <= 1'b0;
         cnt_q     <= '0;
         low_q     <= '0;
         samp_q    <= '0;
         last_q    <= '0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            busy_q    <= 1'b1;
            cnt_q     <= '0;
            low_q     <= low_len;
            samp_q    <= samp_at;
            last_q    <= end_at - 1'b1;
            samp_en_q <= has_samp;
            is_rst_q  <= (cmd_op == OP_RESET);
            fast_q    <= cmd_fast;
            rsp_q     <= 1'b0;
         end else if (busy_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (samp_en_q && (cnt_q == samp_q))
               rsp_q <= is_rst_q ? ~line_s : line_s;
            if (cnt_q == last_q) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign busy     = busy_q;
   assign done     = done_q;
   assign rsp_bit  = rsp_q;
   assign pull_low = busy_q && (cnt_q < low_q);

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done) else $error("done longer than one cycle");                  // R10
   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy))) else $error("done without ending slot");    // R10
   AST_PULL_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      pull_low |-> busy) else $error("line pulled outside a slot");                // R6
   AST_SPEED_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(fast_q)) else $error("speed changed");     // R7
   AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !$past(busy)) |-> $stable(rsp_bit)) else $error("rsp moved idle"); // R9
   AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done && $past(busy) && cnt_q != '0) |-> (cnt_q == $past(cnt_q) + 1'b1))
      else $error("slot restarted while busy");                                    // R8

endmodule

// File: rtl/sw_bus_master.sv
module sw_bus_master
   import sw_bus_pkg::*;
#(
   parameter int unsigned CYC_PER_US  = 125,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_valid,
   input  logic [1:0] cmd_op,
   input  logic       cmd_wbit,
   input  logic       cmd_fast,
   output logic       busy,
   output logic       done,
   output logic       rsp_bit,
   output logic       bus_pull_low,
   input  logic       bus_in
);

   localparam int unsigned MAX_CYC = hus_to_cyc(MAX_HUS, CYC_PER_US);
   localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

   generate
      if (CYC_PER_US < 2) begin : g_bad_rate
         $error("sw_bus_master: CYC_PER_US must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("sw_bus_master: SYNC_STAGES must be at least 2");
      end
   endgenerate

   sw_op_e           op;
   logic             line_s;
   logic [CNT_W-1:0] low_len, samp_at, end_at;
   logic             has_samp;

   assign op = sw_op_e'(cmd_op);

   sw_bus_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b1)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (bus_in),
      .q_sync  (line_s)
   );

   sw_bus_timing #(
      .CYC_PER_US (CYC_PER_US),
      .CNT_W      (CNT_W)
   ) u_timing (
      .sel_fast (cmd_fast),
      .op       (op),
      .wbit     (cmd_wbit),
      .low_len  (low_len),
      .samp_at  (samp_at),
      .end_at   (end_at),
      .has_samp (has_samp)
   );

   sw_bus_seq #(
      .CNT_W (CNT_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_op    (op),
      .cmd_fast  (cmd_fast),
      .low_len   (low_len),
      .samp_at   (samp_at),
      .end_at    (end_at),
      .has_samp  (has_samp),
      .line_s    (line_s),
      .busy      (busy),
      .done      (done),
      .rsp_bit   (rsp_bit),
      .pull_low  (bus_pull_low)
   );

   AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !bus_pull_low) else $error("line held while idle");               // R6
   AST_NONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && cmd_valid && cmd_op == 2'b11) |=> !busy) else $error("op 11 taken"); // R8

endmodule

// File: tb/sw_bus_master_tb.sv
module sw_bus_master_tb;

   localparam int CPU = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [1:0] cmd_op = 2'b11;
   logic       cmd_wbit = 1'b0;
   logic       cmd_fast = 1'b0;
   logic       busy, done, rsp_bit, bus_pull_low, bus_in;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;

   // device model
   int  dev_mode = 0;   // 0 none, 1 presence normal, 2 presence fast, 3 read0 normal, 4 read0 fast
   int  rel_cnt = 100000;
   int  since_cnt = 100000;
   logic pull_prev = 1'b0;
   logic dev_low;

   always #4 clk = ~clk;

   sw_bus_master #(.CYC_PER_US(CPU), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_wbit(cmd_wbit), .cmd_fast(cmd_fast), .busy(busy), .done(done),
      .rsp_bit(rsp_bit), .bus_pull_low(bus_pull_low), .bus_in(bus_in)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      pull_prev <= bus_pull_low;
      if (bus_pull_low && !pull_prev) since_cnt <= 0;
      else if (since_cnt < 100000)    since_cnt <= since_cnt + 1;
      if (!bus_pull_low && pull_prev) rel_cnt <= 0;
      else if (rel_cnt < 100000)      rel_cnt <= rel_cnt + 1;
   end

   assign dev_low = (dev_mode == 1 && rel_cnt >= 60 && rel_cnt < 800) ||
                    (dev_mode == 2 && rel_cnt >= 8  && rel_cnt < 80)  ||
                    (dev_mode == 3 && since_cnt < 80) ||
                    (dev_mode == 4 && since_cnt < 10);
   assign bus_in = !(bus_pull_low || dev_low);

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // issue a command and measure: cycles line held low, cycles to done, result
   task automatic run_cmd(input logic [1:0] op, input logic wb, input logic fast,
                          input int inject_at,
                          output int low_n, output int done_n, output int rsp);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_wbit = wb; cmd_fast = fast;
      @(posedge clk);
      low_n = 0; done_n = -1; rsp = -1;
      for (int n = 0; n < 5000; n++) begin
         @(negedge clk);
         if (n == 0) begin cmd_valid = 1'b0; cmd_op = 2'b11; end
         if (n == inject_at) begin
            cmd_valid = 1'b1; cmd_op = 2'b00; cmd_fast = ~fast; cmd_wbit = ~wb;
         end
         if (n == inject_at + 3) begin cmd_valid = 1'b0; cmd_op = 2'b11; end
         if (bus_pull_low) low_n++;
         if (done) begin done_n = n; rsp = rsp_bit; break; end
      end
      cmd_fast = fast;
   endtask

   task automatic t_reset_state();
      check("R1 busy", busy, 0);
      check("R1 done", done, 0);
      check("R1 rsp_bit", rsp_bit, 0);
      check("R1 pull", bus_pull_low, 0);
   endtask

   task automatic t_bus_reset();
      int l, d, r;
      dev_mode = 1;
      run_cmd(2'b00, 1'b0, 1'b0, -10, l, d, r);
      check("R2 normal low", l, 480 * CPU);
      check("R2 normal end", d, 960 * CPU);
      check("R3 normal present", r, 1);
      dev_mode = 0;
      run_cmd(2'b00, 1'b0, 1'b0, -10, l, d, r);
      check("R3 normal absent", r, 0);
      dev_mode = 2;
      run_cmd(2'b00, 1'b0, 1'b1, -10, l, d, r);
      check("R2 fast low", l, 48 * CPU);
      check("R2 fast end", d, 96 * CPU);
      check("R3 fast present", r, 1);
      dev_mode = 0;
      run_cmd(2'b00, 1'b0, 1'b1, -10, l, d, r);
      check("R3 fast absent", r, 0);
   endtask

   task automatic t_write();
      int l, d, r;
      run_cmd(2'b01, 1'b0, 1'b0, -10, l, d, r);
      check("R4 normal w0 low", l, 60 * CPU);
      check("R6 normal slot", d, 70 * CPU);
      check("R9 write rsp", r, 0);
      run_cmd(2'b01, 1'b1, 1'b0, -10, l, d, r);
      check("R4 normal w1 low", l, 6 * CPU);
      run_cmd(2'b01, 1'b0, 1'b1, -10, l, d, r);
      check("R4 fast w0 low", l, 6 * CPU);
      check("R6 fast slot", d, 10 * CPU);
      run_cmd(2'b01, 1'b1, 1'b1, -10, l, d, r);
      check("R4 fast w1 low", l, 1 * CPU);
   endtask

   task automatic t_read();
      int l, d, r;
      dev_mode = 3;
      run_cmd(2'b10, 1'b0, 1'b0, -10, l, d, r);
      check("R5 normal read0", r, 0);
      dev_mode = 0;
      run_cmd(2'b10, 1'b0, 1'b0, -10, l, d, r);
      check("R5 normal low", l, 5 * CPU);
      check("R6 normal read slot", d, 70 * CPU);
      check("R5 normal read1", r, 1);
      dev_mode = 4;
      run_cmd(2'b10, 1'b0, 1'b1, -10, l, d, r);
      check("R5 fast read0", r, 0);
      dev_mode = 0;
      run_cmd(2'b10, 1'b0, 1'b1, -10, l, d, r);
      check("R5 fast low", l, 1 * CPU);
      check("R5 fast read1", r, 1);
   endtask

   task automatic t_hold_and_clear();
      int l, d, r;
      repeat (50) @(negedge clk);
      check("R9 held", rsp_bit, 1);
      check("R10 done single", done, 0);
      run_cmd(2'b01, 1'b1, 1'b1, -10, l, d, r);
      check("R9 cleared by write", r, 0);
   endtask

   task automatic t_busy_ignore();
      int l, d, r;
      // reset request with flipped speed arrives mid write slot
      run_cmd(2'b01, 1'b0, 1'b0, 20, l, d, r);
      check("R8 ignored low", l, 60 * CPU);
      check("R7 speed held slot", d, 70 * CPU);
      @(negedge clk);
      check("R8 no restart", busy, 0);
      // unused encoding never starts a slot
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 2'b11;
      repeat (5) @(negedge clk);
      cmd_valid = 1'b0;
      check("R8 op11 busy", busy, 0);
      check("R8 op11 pull", bus_pull_low, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset_state();
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      t_reset_state();
      t_bus_reset();
      t_write();
      t_read();
      t_hold_and_clear();
      t_busy_ignore();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   always @(posedge clk) begin
      if (cyc > 150000) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule